// File: doc/BRIEF.md
# Compartment-ID Resource Access Filter

This block guards six resources of a shared peripheral. Each access names a resource index, a 3-bit requester compartment ID and a secure attribute. The block answers grant or deny in the same cycle. It decides from three pieces of per-resource state: a security bit, a compartment-ID filter word and a hardware semaphore.

The filter word selects one of three modes:

- **Filter off:** any requester passes.
- **Static owner:** only one compartment ID passes.
- **Semaphore:** a per-ID allow list is checked first. Then only the compartment that currently holds the resource's mutex passes.

The security bits and filter words can be written only by secure requesters. A non-secure attempt to write them is dropped and flagged with a one-cycle violation pulse. Any requester may take or release a semaphore, subject to the rules below. A status register mirrors a 2-bit readiness indication from the peripheral.

Top module: `cid_access_filter`

## Requirements
- R1: An access whose resource index is 6 or 7 gets `acc_invalid` high and `acc_grant` low. For indices 0 to 5, `acc_invalid` is low.
- R2: A secure requester (`acc_secure`=1) is granted any valid resource, whatever its configuration.
- R3: Bit n of the security register at 0x300 set means any non-secure access to resource n is denied, whatever the filter word says.
- R4: When bit 0 (filter enable) of resource n's filter word at 0x30C+8n is clear, every non-secure requester is granted resource n.
- R5: When filtering is enabled and bit 1 (semaphore mode) is clear, a non-secure requester is granted only if its ID equals bits 6:4 (static owner) of the filter word.
- R6: In semaphore mode, the allow list in bits 23:16 of the filter word has bit 16+id for compartment id. A non-secure requester whose bit is clear is denied even if it holds the mutex.
- R7: In semaphore mode, an allowed non-secure requester is granted only while the mutex is taken and the recorded owner equals its ID.
- R8: The semaphore register of resource n is at 0x310+8n, with bit 0 as the taken flag and bits 6:4 as the owner. Writing bit0=1 while the mutex is free, with the resource in semaphore mode and the writer's allow bit set, takes the mutex and records the writer's ID. Otherwise the write has no effect.
- R9: Writing bit0=0 to a taken semaphore releases it and clears the owner to 0, but only when the writer is the recorded owner. A release by any other compartment has no effect.
- R10: The status register at 0x084 returns `iso_state` in bits 1:0 and zero elsewhere.
- R11: A non-secure write to 0x300 or to any filter word leaves the register unchanged. It sets `wr_violation` high in the following cycle only. Secure writes and semaphore writes never raise it.
- R12: After reset, every security bit, filter word and semaphore reads as zero. Secure writes read back with only the defined fields kept: bits 5:0 at 0x300, and bits 23:16, 6:4, 1 and 0 of a filter word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_secure | input | 1 | Secure attribute of the register writer |
| reg_cid | input | 3 | Compartment ID of the register writer |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| iso_state | input | 2 | Peripheral readiness indication, nonzero while not ready |
| acc_res | input | 3 | Resource index of the access under test |
| acc_cid | input | 3 | Compartment ID of the accessing requester |
| acc_secure | input | 1 | Secure attribute of the accessing requester |
| acc_grant | output | 1 | Access granted |
| acc_invalid | output | 1 | Resource index out of range |
| wr_violation | output | 1 | One-cycle pulse after a dropped non-secure configuration write |

## Verification
Every combination of resource index 0 to 7, requester ID 0 to 7 and secure attribute is swept against a bench-side model. The sweep runs after reset, after a mixed configuration and after each semaphore transition. The mixed configuration puts each resource in a different mode: secured, filter off, static owner, and semaphore with a narrow or full allow list. A mismatch therefore points to the specific layer of the decision that failed.

Semaphore traffic covers takes from a compartment not on the allow list, from a foreign compartment and while filtering is off. It also covers releases by a non-owner, which separates "no effect" from a wrongly applied write. Non-secure configuration writes are each followed by a readback and by a check of the pulse in the cycle after the write and the cycle after that.

// File: rtl/cidf_pkg.sv
// Package: shared constants, register map and state types of the
// compartment-ID access filter. Assumes 12-bit byte addressing.
package cidf_pkg;
    localparam int NUM_RES   = 6;
    localparam int CID_W     = 3;
    localparam int NUM_CID   = 1 << CID_W;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int RES_IDX_W = 3;
    localparam int REG_STEP  = 8;

    localparam logic [ADDR_W-1:0] SECMASK_ADDR = 12'h300;
    localparam logic [ADDR_W-1:0] FILTER_BASE  = 12'h30C;
    localparam logic [ADDR_W-1:0] SEMA_BASE    = 12'h310;
    localparam logic [ADDR_W-1:0] STATUS_ADDR  = 12'h084;

    // Field positions inside a filter word.
    localparam int FLT_EN_BIT  = 0;
    localparam int FLT_SEM_BIT = 1;
    localparam int FLT_ID_LSB  = 4;
    localparam int FLT_AL_LSB  = 16;

    typedef struct packed {
        logic [NUM_CID-1:0] allow;
        logic [CID_W-1:0]   owner_id;
        logic               sem_mode;
        logic               enable;
    } filt_cfg_t;

    typedef struct packed {
        logic             taken;
        logic [CID_W-1:0] holder;
    } sema_t;

    // Byte address of the filter word of resource n.
    function automatic logic [ADDR_W-1:0] filter_addr(input int n);
        return FILTER_BASE + ADDR_W'(REG_STEP * n);
    endfunction

    // Byte address of the semaphore register of resource n.
    function automatic logic [ADDR_W-1:0] sema_addr(input int n);
        return SEMA_BASE + ADDR_W'(REG_STEP * n);
    endfunction
endpackage

// File: rtl/cidf_cfg_regs.sv
// Module: security mask and per-resource filter words. Only secure writers
// may change them; a non-secure write to any of them is dropped and raises
// a registered one-cycle violation flag. Assumes a single write port.
module cidf_cfg_regs
    import cidf_pkg::*;
#(
    parameter int N_RES = NUM_RES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              secure,
    output logic [N_RES-1:0]  sec_mask,
    output filt_cfg_t         cfg [N_RES],
    output logic              violation
);
    logic [N_RES-1:0] flt_hit;

    // Address match per filter word.
    always_comb begin
        for (int i = 0; i < N_RES; i++) begin
            flt_hit[i] = (addr == filter_addr(i));
        end
    end

    // Security mask register, secure writers only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_mask <= '0;
        end else if (wr && secure && addr == SECMASK_ADDR) begin
            sec_mask <= wdata[N_RES-1:0];
        end
    end

    generate
        for (genvar n = 0; n < N_RES; n++) begin : g_flt
            // Filter word of resource n, secure writers only.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg[n] <= '0;
                end else if (wr && secure && flt_hit[n]) begin
                    cfg[n].enable   <= wdata[FLT_EN_BIT];
                    cfg[n].sem_mode <= wdata[FLT_SEM_BIT];
                    cfg[n].owner_id <= wdata[FLT_ID_LSB +: CID_W];
                    cfg[n].allow    <= wdata[FLT_AL_LSB +: NUM_CID];
                end
            end
        end
    endgenerate

    // One-cycle flag for a dropped non-secure configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            violation <= 1'b0;
        end else begin
            violation <= wr && !secure && ((addr == SECMASK_ADDR) || (|flt_hit));
        end
    end
endmodule

// File: rtl/cidf_sema.sv
// Module: hardware mutex of one resource. A take succeeds only when the
// mutex is free, the resource is in semaphore mode and the writer is on the
// allow list; a release succeeds only for the recorded holder.
module cidf_sema
    import cidf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             wbit,
    input  logic [CID_W-1:0] wcid,
    input  filt_cfg_t        cfg,
    output sema_t            state
);
    logic may_take;
    logic may_free;

    // Legality of the pending take or release.
    always_comb begin
        may_take = hit && wbit && !state.taken && cfg.enable && cfg.sem_mode
                   && cfg.allow[wcid];
        may_free = hit && !wbit && state.taken && (state.holder == wcid);
    end

    // Mutex state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
        end else if (may_take) begin
            state.taken  <= 1'b1;
            state.holder <= wcid;
        end else if (may_free) begin
            state <= '0;
        end
    end
endmodule

// File: rtl/cidf_decide.sv
// Module: combinational grant decision. The layers are tried in order:
// index range, secure requester, security bit, filter enable, static owner,
// allow list, mutex holder.
module cidf_decide
    import cidf_pkg::*;
#(
    parameter int N_RES = NUM_RES
) (
    input  logic [RES_IDX_W-1:0] res,
    input  logic [CID_W-1:0]     cid,
    input  logic                 secure,
    input  logic [N_RES-1:0]     sec_mask,
    input  filt_cfg_t            cfg [N_RES],
    input  sema_t                sema [N_RES],
    output logic                 grant,
    output logic                 invalid
);
    filt_cfg_t sel_cfg;
    sema_t     sel_sem;
    logic      sel_sec;

    // Pick the state of the addressed resource.
    always_comb begin
        sel_cfg = '0;
        sel_sem = '0;
        sel_sec = 1'b0;
        invalid = 1'b1;
        for (int i = 0; i < N_RES; i++) begin
            if (res == RES_IDX_W'(i)) begin
                sel_cfg = cfg[i];
                sel_sem = sema[i];
                sel_sec = sec_mask[i];
                invalid = 1'b0;
            end
        end
    end

    // Layered grant decision.
    always_comb begin
        if (invalid)                   grant = 1'b0;
        else if (secure)               grant = 1'b1;
        else if (sel_sec)              grant = 1'b0;
        else if (!sel_cfg.enable)      grant = 1'b1;
        else if (!sel_cfg.sem_mode)    grant = (cid == sel_cfg.owner_id);
        else if (!sel_cfg.allow[cid])  grant = 1'b0;
        else                           grant = sel_sem.taken && (sel_sem.holder == cid);
    end
endmodule

// File: rtl/cid_access_filter.sv
// Module: top of the compartment-ID access filter. Ties the configuration
// registers, one mutex per resource and the decision logic together and
// provides the combinational register read path.
module cid_access_filter
    import cidf_pkg::*;
#(
    parameter int N_RES = NUM_RES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 reg_secure,
    input  logic [CID_W-1:0]     reg_cid,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [1:0]           iso_state,
    input  logic [RES_IDX_W-1:0] acc_res,
    input  logic [CID_W-1:0]     acc_cid,
    input  logic                 acc_secure,
    output logic                 acc_grant,
    output logic                 acc_invalid,
    output logic                 wr_violation
);
    logic [N_RES-1:0] sec_mask;
    filt_cfg_t        cfg_q [N_RES];
    sema_t            sem_q [N_RES];

    cidf_cfg_regs #(.N_RES(N_RES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .secure(reg_secure), .sec_mask(sec_mask),
        .cfg(cfg_q), .violation(wr_violation)
    );

    generate
        for (genvar n = 0; n < N_RES; n++) begin : g_sem
            cidf_sema u_sem (
                .clk(clk), .rst_n(rst_n),
                .hit(reg_wr && reg_addr == sema_addr(n)),
                .wbit(reg_wdata[0]), .wcid(reg_cid),
                .cfg(cfg_q[n]), .state(sem_q[n])
            );
        end
    endgenerate

    cidf_decide #(.N_RES(N_RES)) u_dec (
        .res(acc_res), .cid(acc_cid), .secure(acc_secure),
        .sec_mask(sec_mask), .cfg(cfg_q), .sema(sem_q),
        .grant(acc_grant), .invalid(acc_invalid)
    );

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == STATUS_ADDR) reg_rdata[1:0] = iso_state;
        if (reg_addr == SECMASK_ADDR) reg_rdata[N_RES-1:0] = sec_mask;
        for (int i = 0; i < N_RES; i++) begin
            if (reg_addr == filter_addr(i)) begin
                reg_rdata[FLT_EN_BIT]                = cfg_q[i].enable;
                reg_rdata[FLT_SEM_BIT]               = cfg_q[i].sem_mode;
                reg_rdata[FLT_ID_LSB +: CID_W]       = cfg_q[i].owner_id;
                reg_rdata[FLT_AL_LSB +: NUM_CID]     = cfg_q[i].allow;
            end
            if (reg_addr == sema_addr(i)) begin
                reg_rdata[0]                  = sem_q[i].taken;
                reg_rdata[FLT_ID_LSB +: CID_W] = sem_q[i].holder;
            end
        end
    end
endmodule

// File: rtl/cidf_checker.sv
// Module: property checker for cid_access_filter, attached with bind.
module cidf_checker
    import cidf_pkg::*;
#(
    parameter int N_RES = NUM_RES
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic                 reg_secure,
    input logic [CID_W-1:0]     reg_cid,
    input logic [RES_IDX_W-1:0] acc_res,
    input logic                 acc_secure,
    input logic                 acc_grant,
    input logic                 acc_invalid,
    input logic                 wr_violation,
    input logic [N_RES-1:0]     sec_mask,
    input sema_t                sem_q [N_RES]
);
    logic idx_ok;
    logic sec_hit;
    assign idx_ok  = (int'(acc_res) < N_RES);
    assign sec_hit = |((sec_mask >> acc_res) & N_RES'(1));

    a_r1_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_ok |-> (acc_invalid && !acc_grant));

    a_r2_secure_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_ok && acc_secure) |-> acc_grant);

    a_r3_secure_bit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_ok && !acc_secure && sec_hit) |-> !acc_grant);

    a_r11_pulse_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_secure && reg_addr == SECMASK_ADDR) |=> wr_violation);

    a_r11_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_secure && reg_addr == SECMASK_ADDR) |=> $stable(sec_mask));

    a_r11_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wr_violation |-> $past(reg_wr && !reg_secure));

    a_r9_foreign_release: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEMA_BASE && sem_q[0].taken && sem_q[0].holder != reg_cid)
        |=> (sem_q[0].taken && $stable(sem_q[0].holder)));
endmodule

bind cid_access_filter cidf_checker #(.N_RES(N_RES)) u_cidf_checker (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_secure(reg_secure), .reg_cid(reg_cid), .acc_res(acc_res),
    .acc_secure(acc_secure), .acc_grant(acc_grant), .acc_invalid(acc_invalid),
    .wr_violation(wr_violation), .sec_mask(sec_mask), .sem_q(sem_q)
);

// File: tb/test_cid_access_filter.sv
module test_cid_access_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_secure = 1'b0;
    logic [2:0]  reg_cid = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  iso_state = '0;
    logic [2:0]  acc_res = '0;
    logic [2:0]  acc_cid = '0;
    logic        acc_secure = 1'b0;
    logic        acc_grant;
    logic        acc_invalid;
    logic        wr_violation;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model of the programmed state.
    bit       m_sec   [6];
    bit       m_en    [6];
    bit       m_sem   [6];
    bit [2:0] m_id    [6];
    bit [7:0] m_allow [6];
    bit       m_taken [6];
    bit [2:0] m_owner [6];

    always #10 clk = ~clk;

    cid_access_filter i_cid_access_filter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_secure(reg_secure), .reg_cid(reg_cid),
        .reg_rdata(reg_rdata), .iso_state(iso_state), .acc_res(acc_res),
        .acc_cid(acc_cid), .acc_secure(acc_secure), .acc_grant(acc_grant),
        .acc_invalid(acc_invalid), .wr_violation(wr_violation)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string which_req(int r, int c, bit s);
        if (r >= 6) return "R1";
        if (s) return "R2";
        if (m_sec[r]) return "R3";
        if (!m_en[r]) return "R4";
        if (!m_sem[r]) return "R5";
        if (!m_allow[r][c]) return "R6";
        return "R7";
    endfunction

    function automatic bit exp_grant(int r, int c, bit s);
        if (r >= 6) return 0;
        if (s) return 1;
        if (m_sec[r]) return 0;
        if (!m_en[r]) return 1;
        if (!m_sem[r]) return c == m_id[r];
        if (!m_allow[r][c]) return 0;
        return m_taken[r] && m_owner[r] == c;
    endfunction

    // Full sweep of index, ID and secure attribute.
    task automatic sweep();
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                for (int s = 0; s < 2; s++) begin
                    acc_res = 3'(r); acc_cid = 3'(c); acc_secure = s[0];
                    #1;
                    check(which_req(r, c, s[0]), {30'b0, acc_invalid, acc_grant},
                          {30'b0, (r >= 6), exp_grant(r, c, s[0])});
                end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, bit sec, logic [2:0] c);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_secure = sec; reg_cid = c;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    function automatic logic [31:0] flt_word(int r);
        return {8'h0, m_allow[r], 9'h0, m_id[r], 2'b0, m_sem[r], m_en[r]};
    endfunction

    task automatic set_flt(int r, bit en, bit sem, bit [2:0] id, bit [7:0] al);
        wr(12'h30C + 12'(8 * r), 32'hFF00_FF8C | {8'h0, al, 9'h0, id, 2'b0, sem, en}
           & 32'h00FF_0073, 1'b1, 3'd0);
        check("R11 secure write pulse", {31'b0, wr_violation}, 32'd0);
        m_en[r] = en; m_sem[r] = sem; m_id[r] = id; m_allow[r] = al;
        rd("R12 filter readback", 12'h30C + 12'(8 * r), flt_word(r));
    endtask

    task automatic sem_wr(int r, bit b, bit [2:0] c);
        wr(12'h310 + 12'(8 * r), {31'h7FFF_FFF0, b}, 1'b0, c);
        check("R11 semaphore write pulse", {31'b0, wr_violation}, 32'd0);
        if (b && !m_taken[r] && m_en[r] && m_sem[r] && m_allow[r][c]) begin
            m_taken[r] = 1; m_owner[r] = c;
        end else if (!b && m_taken[r] && m_owner[r] == c) begin
            m_taken[r] = 0; m_owner[r] = 0;
        end
        rd(b ? "R8 semaphore take" : "R9 semaphore release", 12'h310 + 12'(8 * r),
           {25'b0, m_owner[r], 3'b0, m_taken[r]});
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check("R11 idle pulse", {31'b0, wr_violation}, 32'd0);
        rd("R12 reset mask", 12'h300, 32'd0);
        for (int r = 0; r < 6; r++) begin
            rd("R12 reset filter", 12'h30C + 12'(8 * r), 32'd0);
            rd("R12 reset semaphore", 12'h310 + 12'(8 * r), 32'd0);
        end
        sweep();

        // R10: status mirror
        for (int v = 0; v < 4; v++) begin
            iso_state = 2'(v);
            rd("R10 status", 12'h084, 32'(v));
        end

        // Mixed configuration: one mode per resource.
        wr(12'h300, 32'hFFFF_FFC4, 1'b1, 3'd2);
        check("R11 secure write pulse", {31'b0, wr_violation}, 32'd0);
        for (int r = 0; r < 6; r++) m_sec[r] = (r == 2);
        rd("R12 mask readback", 12'h300, 32'h0000_0004);
        set_flt(0, 0, 0, 3'd5, 8'hFF);
        set_flt(1, 1, 0, 3'd3, 8'h00);
        set_flt(2, 0, 0, 3'd0, 8'h00);
        set_flt(3, 1, 1, 3'd7, 8'h06);
        set_flt(4, 1, 0, 3'd0, 8'hFF);
        set_flt(5, 1, 1, 3'd0, 8'hFF);
        sweep();

        // Semaphore traffic.
        sem_wr(3, 1, 3'd5);   // R8 not on allow list
        sem_wr(0, 1, 3'd1);   // R8 filter off
        sem_wr(1, 1, 3'd3);   // R8 static mode
        sem_wr(3, 1, 3'd2);   // R8 take
        sem_wr(3, 1, 3'd1);   // R8 foreign take while held
        sem_wr(3, 0, 3'd1);   // R9 foreign release
        sweep();
        sem_wr(3, 0, 3'd2);   // R9 owner release
        sem_wr(3, 1, 3'd1);   // R8 new owner
        sem_wr(5, 1, 3'd7);   // R8 full allow list
        sweep();
        set_flt(3, 1, 1, 3'd7, 8'h04);   // R6 holder dropped from allow list
        sweep();

        // R11: non-secure configuration writes are dropped.
        wr(12'h300, 32'h0000_003F, 1'b0, 3'd1);
        check("R11 pulse after mask write", {31'b0, wr_violation}, 32'd1);
        @(negedge clk);
        check("R11 pulse ends", {31'b0, wr_violation}, 32'd0);
        rd("R11 mask unchanged", 12'h300, 32'h0000_0004);
        wr(12'h314, 32'h0000_0001, 1'b0, 3'd1);
        check("R11 pulse after filter write", {31'b0, wr_violation}, 32'd1);
        @(negedge clk);
        check("R11 pulse ends", {31'b0, wr_violation}, 32'd0);
        rd("R11 filter unchanged", 12'h314, flt_word(1));
        sweep();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule